// File: doc/BRIEF.md
# Resettable Pixel Clock Divider

This block turns a fast reference clock into a slower pixel clock by dividing it by one of nine moduli. The output keeps an even split between high and low time for every modulus. For the odd ones, a register clocked on the falling edge of the fast clock adds the missing half period.

A restart input lets an external line-sync event, such as a conditioned beam detect, realign the pixel clock. The polarity of that input is set by a configuration bit. When the restart input becomes active, the divider reloads. The first low phase of the output starts a fixed two fast-clock periods after the assertion is detected, so the phase is resolved to one fast-clock period. When the restart input goes inactive, the cycle in progress runs to its end and the output then stays high until the next assertion.

The modulus code and the polarity bit are treated as static configuration. A new modulus code is picked up only at the next restart.

Top module: `pixel_clk_div`

## Requirements
- R1: The 4-bit `mod_sel` code chooses the modulus. Codes 0 through 8 give 3, 4, 5, 6, 8, 10, 12, 16 and 20 in that order. Codes 9 through 15 give 4.
- R2: While running with modulus N, every output period is N fast-clock periods long. Each period is low for the first N half-periods and high for the next N, for odd N as well as even N.
- R3: A restart is detected on the rising clock edge where the enable is active and was inactive at the previous edge. The output goes low on the second rising edge after that detection edge and stays low for the first half of the period.
- R4: With `en_pol` = 0 the enable is active when `en_in` is 0. With `en_pol` = 1 the enable is active when `en_in` is 1.
- R5: Let a period begin on edge S. If the enable is sampled inactive on edge S+N-1, no further period starts. The output completes its high phase and then stays high until the next detected restart.
- R6: A change of `mod_sel` while the divider is running has no effect on the output. The modulus is captured on the detection edge.
- R7: While `rst_n` is low, and after its release until a restart is detected, the output is high. The enable is taken as inactive before the first edge.
- R8: The enable must be inactive for at least N fast-clock periods before it is reasserted. Under that rule a restart never arrives while a period is still in progress.
- R9: While the enable stays active, periods follow one another with no gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mod_sel | input | 4 | Modulus select code |
| en_pol | input | 1 | Enable polarity: 0 active low, 1 active high |
| en_in | input | 1 | Restart / enable input |
| pclk_out | output | 1 | Pixel clock output |

## Verification
Detection happens on the rising edge that samples the active enable. The output falls two rising edges later, and from then on its level is a function of the half-period count since that edge. The bench therefore compares the output twice per fast-clock cycle: once a quarter period after the rising edge and once a quarter period after the falling edge, which catches the half-period stretch used by the odd moduli. The stop decision falls on the last rising edge of each period. The bench takes it from the enable level it drove before that edge, and the inputs are always changed late in a cycle, away from both clock edges.

// File: rtl/pclkdiv_pkg.sv
package pclkdiv_pkg;

  localparam int SEL_W = 4;
  localparam int CNT_W = 5;

  // R1: modulus lookup, unused codes fall back to four
  function automatic logic [CNT_W-1:0] modulus_of(input logic [SEL_W-1:0] sel);
    logic [CNT_W-1:0] m;
    case (sel)
      4'd0:    m = 5'd3;
      4'd1:    m = 5'd4;
      4'd2:    m = 5'd5;
      4'd3:    m = 5'd6;
      4'd4:    m = 5'd8;
      4'd5:    m = 5'd10;
      4'd6:    m = 5'd12;
      4'd7:    m = 5'd16;
      4'd8:    m = 5'd20;
      default: m = 5'd4;
    endcase
    return m;
  endfunction

  // count value at which the posedge phase register goes high
  function automatic logic [CNT_W-1:0] rise_point(input logic [CNT_W-1:0] m);
    return m >> 1;
  endfunction

  function automatic logic is_odd(input logic [CNT_W-1:0] m);
    return m[0];
  endfunction

endpackage

// File: rtl/pclkdiv_en_detect.sv
module pclkdiv_en_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  input  logic en_pol,
  output logic en_act,
  output logic rise_det
);

  logic en_q;

  assign en_act   = en_pol ? en_in : ~en_in;
  assign rise_det = en_act & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_act;
  end

  // R4
  pol_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_det |-> (en_in == en_pol));

endmodule

// File: rtl/pclkdiv_counter.sv
module pclkdiv_counter
  import pclkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_det,
  input  logic             en_act,
  input  logic [SEL_W-1:0] mod_sel,
  output logic             phase_hi,
  output logic             odd_mode,
  output logic             running
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] div_q;
  logic             load_pend;
  logic             wrap;

  assign wrap     = running && (cnt == div_q - 5'd1);
  assign odd_mode = is_odd(div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      div_q     <= 5'd4;
      load_pend <= 1'b0;
      running   <= 1'b0;
      phase_hi  <= 1'b1;
    end else begin
      load_pend <= rise_det;
      if (rise_det) div_q <= modulus_of(mod_sel);
      phase_hi <= running ? (cnt >= rise_point(div_q)) : 1'b1;
      if (load_pend) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (wrap) begin
          cnt <= '0;
          if (!en_act) running <= 1'b0;
        end else begin
          cnt <= cnt + 5'd1;
        end
      end
    end
  end

  // R8
  restart_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_det |-> !running);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < div_q);

  // R3
  load_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_pend |=> (running && cnt == '0));

  // R3
  first_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && cnt == '0) |=> !phase_hi);

  // R5
  park_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> phase_hi);

  // R6
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> $stable(div_q));

endmodule

// File: rtl/pclkdiv_half_stretch.sv
module pclkdiv_half_stretch (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_hi,
  input  logic odd_mode,
  output logic pclk_out
);

  logic late_hi;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) late_hi <= 1'b1;
    else        late_hi <= phase_hi;
  end

  // R2: odd moduli rise half a period after the posedge register
  assign pclk_out = odd_mode ? (phase_hi & late_hi) : phase_hi;

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_hi && late_hi) |-> pclk_out);

endmodule

// File: rtl/pixel_clk_div.sv
module pixel_clk_div
  import pclkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] mod_sel,
  input  logic             en_pol,
  input  logic             en_in,
  output logic             pclk_out
);

  logic en_act;
  logic rise_det;
  logic phase_hi;
  logic odd_mode;
  logic running;

  pclkdiv_en_detect u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_in    (en_in),
    .en_pol   (en_pol),
    .en_act   (en_act),
    .rise_det (rise_det)
  );

  pclkdiv_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .rise_det (rise_det),
    .en_act   (en_act),
    .mod_sel  (mod_sel),
    .phase_hi (phase_hi),
    .odd_mode (odd_mode),
    .running  (running)
  );

  pclkdiv_half_stretch u_str (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase_hi (phase_hi),
    .odd_mode (odd_mode),
    .pclk_out (pclk_out)
  );

  // R7
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !$past(running)) |-> pclk_out);

endmodule

// File: tb/pixel_clk_div_test.sv
module pixel_clk_div_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] mod_sel = 4'd0;
  logic       en_pol = 1'b1;
  logic       en_in = 1'b0;
  logic       pclk_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  string req = "R7";

  // model state
  int  edge_no = 0;
  bit  m_prev = 0;
  bit  m_run = 0;
  int  m_start = 0;
  int  m_n = 4;

  always #4 clk = ~clk;

  pixel_clk_div uut (
    .clk(clk), .rst_n(rst_n), .mod_sel(mod_sel),
    .en_pol(en_pol), .en_in(en_in), .pclk_out(pclk_out)
  );

  function automatic int ref_mod(input int code);
    if (code <= 3) return code + 3;
    if (code <= 6) return 2 * code;
    if (code == 7) return 16;
    if (code == 8) return 20;
    return 4;
  endfunction

  function automatic bit ref_level(input int e, input int half);
    int p;
    if (!m_run || e < m_start) return 1'b1;
    p = 2 * (e - m_start) + half;
    return ((p % (2 * m_n)) < m_n) ? 1'b0 : 1'b1;
  endfunction

  task automatic compare(input bit exp_v);
    compared++;
    if (pclk_out !== exp_v) begin
      mismatched++;
      $display("FAIL %s edge %0d: pclk_out=%b expected %b", req, edge_no, pclk_out, exp_v);
    end
  endtask

  // one fast-clock cycle: model at the edge, then two samples
  task automatic step();
    bit act;
    @(posedge clk);
    act = en_pol ? en_in : !en_in;
    if (rst_n) begin
      if (m_run && edge_no >= m_start &&
          ((edge_no - m_start) % m_n) == m_n - 1 && !act)
        m_run = 0;                       // R5 stop decision
      if (act && !m_prev) begin          // R3 detection
        if (m_run && edge_no >= m_start)
          $display("NOTE: enable gap shorter than one output period at edge %0d", edge_no);
        m_run = 1;
        m_start = edge_no + 2;
        m_n = ref_mod(int'(mod_sel));
      end
      m_prev = act;
    end
    #2;
    compare(rst_n ? ref_level(edge_no, 0) : 1'b1);
    #4;
    compare(rst_n ? ref_level(edge_no, 1) : 1'b1);
    #1;
    if (rst_n) edge_no++;
  endtask

  task automatic run_cycles(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #3;
    // R7: reset holds output high
    req = "R7";
    run_cycles(4);
    rst_n = 1'b1;
    run_cycles(6);

    // R1 R2 R3 R9: every code, active-high enable
    for (int c = 0; c < 16; c++) begin
      if (c > 8 && c != 9 && c != 15) continue;
      req = "R1 R2 R3 R9";
      mod_sel = 4'(c);
      en_in = 1'b1;
      run_cycles(3 * ref_mod(c) + 5);
      req = "R5";
      en_in = 1'b0;
      run_cycles(2 * ref_mod(c) + 6);
    end

    // R4: active-low polarity
    req = "R4";
    en_in = 1'b1;
    en_pol = 1'b0;
    mod_sel = 4'd2;
    run_cycles(4);
    en_in = 1'b0;
    run_cycles(23);
    en_in = 1'b1;
    run_cycles(16);

    // R6: code change while running is ignored
    req = "R6";
    en_pol = 1'b1;
    en_in = 1'b0;
    run_cycles(3);
    mod_sel = 4'd6;
    en_in = 1'b1;
    run_cycles(7);
    mod_sel = 4'd0;
    run_cycles(40);
    en_in = 1'b0;
    run_cycles(30);

    // R5 R8: single-cycle pulse gives one full period then parks
    req = "R5 R8";
    mod_sel = 4'd4;
    en_in = 1'b1;
    run_cycles(1);
    en_in = 1'b0;
    run_cycles(20);
    en_in = 1'b1;
    run_cycles(1);
    en_in = 1'b0;
    run_cycles(20);

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule